// File: doc/BRIEF.md
# TDM Serial Audio Transmitter

This block sends audio words on one serial data line in time-division-multiplexed frames. It derives a bit clock from the system clock through a programmable divider, counts bit positions and slots, and produces a frame sync that either marks a single bit or spans a whole word. A 32-bit slot mask chooses which slots carry data. Data line enable is low in a masked slot, so the line is released there. Every signal is in the system clock domain. The bit clock leaves as a registered output, and data and frame sync change only on the bit-clock edge that the polarity control selects as the launching edge.

Software-facing control appears as plain input fields: enable, network mode, polarity, frame-sync length and timing, a 5-bit slot/word geometry code, the number of slots per frame, and the divider settings. A one-word holding register feeds a slot-wide shift register. Flags report that the holding register is empty, that the empty condition arose at an odd slot, and that a slot started with no fresh word, in which case the previous word is sent again. After reset, sequencing starts at once. Enable only gates the data line. A cleared enable takes effect at the next slot boundary, and a set enable takes effect at the next frame start.

Top module: `tdm_audio_tx`

## Requirements
- R1: The bit-clock period is 2*max(2, P*(div_m1+1)) system clocks, where P is 8 when pre8_en is 1 and 1 otherwise, so the period ranges from 4 to 4096 clocks.
- R2: With bclk_pol=0, sd_out, sd_oe and fsync change only when bclk rises. With bclk_pol=1 they change only when bclk falls. They hold steady across the other bclk edge.
- R3: geom_code selects (slot bits, word bits) by counting through the slot sizes 8, 12, 16, 20, 24, 32 in ascending order, and within each slot size through the word sizes 8, 12, 16, 20, 24 that do not exceed it. This gives codes 0 to 19, starting (8,8), (12,8), (12,12), (16,8) and ending (32,24). Codes 20 to 31 act as (24,24).
- R4: A word of W bits is taken from wr_data[23:24-W] and sent MSB first, starting at bit 0 of its slot. Slot bits W and above are sent as 0.
- R5: With fs_long=0, fsync is high for exactly one bit period, the last bit of the last slot of a frame. With fs_long=1 and fs_early=0, it is high for bits 0 to W-1 of slot 0. With fs_long=1 and fs_early=1, it is high for the last bit of the previous frame and bits 0 to W-2 of slot 0.
- R6: With net_mode=1, a frame holds last_slot+1 slots. With net_mode=0, a frame holds one slot and last_slot is ignored.
- R7: Bit n of the slot mask belongs to slot n. The mask is all ones after reset and loads from mask_in when mask_wr is high. In a slot whose bit is 0, sd_oe is 0, no word transfers, and empty keeps its value.
- R8: At the start of each transmitting slot, the holding register moves to the shift register and empty is set. odd_empty is set to 1 if that slot index is odd and to 0 if it is even. A write (wr_en) clears empty and odd_empty.
- R9: If empty is 1 when a transmitting slot starts, the word last written is sent again and underrun is set. The next write clears underrun.
- R10: When tx_en is cleared, the slot in progress finishes, and sd_oe then stays 0 until the first slot 0 that begins with tx_en set. Setting tx_en in mid-frame has no effect before the next frame start.
- R11: fs_slot is 1 throughout slot 0 and 0 in every other slot.
- R12: During reset, bclk, sd_oe, fsync, fs_slot, odd_empty and underrun are 0 and empty is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| net_mode | input | 1 | 1: multi-slot frames; 0: one slot per frame |
| bclk_pol | input | 1 | 0: launch on rising bclk; 1: launch on falling bclk |
| fs_long | input | 1 | 0: one-bit sync; 1: word-long sync |
| fs_early | input | 1 | Word-long sync starts one bit early |
| geom_code | input | 5 | Slot/word length code |
| last_slot | input | 5 | Index of the last slot in a network frame |
| pre8_en | input | 1 | Insert the fixed divide-by-8 stage |
| div_m1 | input | 8 | Programmable divider value minus one |
| mask_wr | input | 1 | Load strobe for the slot mask |
| mask_in | input | 32 | New slot mask value |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 24 | Word to transmit, left aligned |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Data line enable, low when the line is released |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| fs_slot | output | 1 | High during slot 0 |
| empty | output | 1 | Holding register empty |
| odd_empty | output | 1 | Empty condition arose at an odd slot |
| underrun | output | 1 | A slot started with no fresh word |

## Verification
The sweep runs all 32 geometry codes and rotates through polarity and sync modes. A wrong code table or wrong padding shows up as shifted or leaking bits at the word boundary. An off-by-one early sync appears one bit away from where the bench expects it. Separate runs cover three corners. Masked slots must keep the line released without consuming a word. Dropping the enable in mid-frame must finish the current slot and stay silent until the next frame. A skipped write must resend the old word and raise underrun, and a design that shifted stale zeros or failed to flag it is caught at the next slot start. Divider settings at both extremes, including the clamped fastest rate, check the bit-clock period.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int DATA_W   = 24;
    localparam int SLOT_MAX = 32;
    localparam int IDX_W    = $clog2(SLOT_MAX);
    localparam int POS_W    = $clog2(SLOT_MAX) + 1;

    typedef struct packed {
        logic [POS_W-1:0] slot_len;
        logic [POS_W-1:0] word_len;
    } geom_t;

    typedef enum logic [1:0] {
        FS_BIT          = 2'd0,
        FS_WORD_ALIGNED = 2'd1,
        FS_WORD_EARLY   = 2'd2
    } fs_mode_e;

    function automatic geom_t mk_geom(input int s, input int w);
        geom_t g;
        g.slot_len = POS_W'(s);
        g.word_len = POS_W'(w);
        return g;
    endfunction

    // Codes walk slot sizes upward, and inside each slot the word sizes that fit.
    function automatic geom_t decode_geom(input logic [4:0] code);
        geom_t g;
        case (code)
            5'd0:  g = mk_geom(8, 8);
            5'd1:  g = mk_geom(12, 8);
            5'd2:  g = mk_geom(12, 12);
            5'd3:  g = mk_geom(16, 8);
            5'd4:  g = mk_geom(16, 12);
            5'd5:  g = mk_geom(16, 16);
            5'd6:  g = mk_geom(20, 8);
            5'd7:  g = mk_geom(20, 12);
            5'd8:  g = mk_geom(20, 16);
            5'd9:  g = mk_geom(20, 20);
            5'd10: g = mk_geom(24, 8);
            5'd11: g = mk_geom(24, 12);
            5'd12: g = mk_geom(24, 16);
            5'd13: g = mk_geom(24, 20);
            5'd14: g = mk_geom(24, 24);
            5'd15: g = mk_geom(32, 8);
            5'd16: g = mk_geom(32, 12);
            5'd17: g = mk_geom(32, 16);
            5'd18: g = mk_geom(32, 20);
            5'd19: g = mk_geom(32, 24);
            default: g = mk_geom(24, 24);
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen #(
    parameter int DIV_W    = 8,
    parameter int PRE_DIV  = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             clk_pol,
    output logic             bclk,
    output logic             launch
);
    localparam int HALF_W = DIV_W + $clog2(PRE_DIV) + 1;

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] cnt;
    logic              wrap;

    // Half period in system clocks, clamped so the bit clock never exceeds clk/4.
    always_comb begin
        half = HALF_W'(div_m1) + HALF_W'(1);
        if (pre_en)
            half = half * HALF_W'(PRE_DIV);
        if (half < HALF_W'(MIN_HALF))
            half = HALF_W'(MIN_HALF);
    end

    assign wrap   = (cnt >= half - 1'b1);
    // The coming toggle moves bclk to the launching level.
    assign launch = wrap && (bclk == clk_pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (rst)
        launch |=> (bclk != clk_pol)) else $error("launch edge polarity"); // R2

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq import tdm_tx_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             tx_en,
    input  logic [POS_W-1:0] slot_len,
    input  logic [POS_W-1:0] word_len,
    input  logic [IDX_W-1:0] last_slot,
    input  fs_mode_e         fs_mode,
    output logic [POS_W-1:0] bitc,
    output logic             slot_start,
    output logic [IDX_W-1:0] next_slot,
    output logic             next_on,
    output logic             fsync,
    output logic             fs_slot
);
    logic [IDX_W-1:0] slot;
    logic             tx_on;
    logic             primed;
    logic             bit_last, slot_last;
    logic             at_tail, at_head, early_head;

    always_comb begin
        bit_last   = (bitc >= slot_len - 1'b1);
        slot_last  = (slot >= last_slot);
        next_slot  = slot_last ? '0 : slot + 1'b1;
        // Enable is honoured at frame start; dropping it ends output at any slot edge.
        next_on    = (next_slot == '0) ? tx_en : (tx_on & tx_en);
        slot_start = launch & bit_last;
        at_tail    = primed && (slot == last_slot) && (bitc == slot_len - 1'b1);
        at_head    = primed && (slot == '0) && (bitc < word_len);
        early_head = primed && (slot == '0) && ((bitc + 1'b1) < word_len);
        case (fs_mode)
            FS_WORD_ALIGNED: fsync = at_head;
            FS_WORD_EARLY:   fsync = at_tail | early_head;
            default:         fsync = at_tail;
        endcase
        fs_slot = primed && (slot == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '1;
            bitc   <= '1;
            tx_on  <= 1'b0;
            primed <= 1'b0;
        end else if (launch) begin
            primed <= 1'b1;
            if (bit_last) begin
                bitc  <= '0;
                slot  <= next_slot;
                tx_on <= next_on;
            end else begin
                bitc <= bitc + 1'b1;
            end
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        launch && bit_last && slot_last |=> (slot == '0) && (bitc == '0)) else $error("frame wrap"); // R6

    AST_RESUME_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !tx_on |=> !tx_on || ((slot == '0) && (bitc == '0))) else $error("resume off frame start"); // R10

endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift import tdm_tx_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic                slot_start,
    input  logic                next_on,
    input  logic [IDX_W-1:0]    next_slot,
    input  logic [POS_W-1:0]    bitc,
    input  logic [POS_W-1:0]    word_len,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                mask_wr,
    input  logic [SLOT_MAX-1:0] mask_in,
    output logic                sd_out,
    output logic                sd_oe,
    output logic                empty,
    output logic                odd_empty,
    output logic                underrun
);
    localparam int PAD_W = SLOT_MAX - DATA_W;

    logic [SLOT_MAX-1:0] mask;
    logic [SLOT_MAX-1:0] shreg;
    logic [DATA_W-1:0]   hold;
    logic                live;
    logic                load_go;

    assign load_go = slot_start & next_on & mask[next_slot];
    assign sd_oe   = live;
    // Bits past the word are padded with zeros up to the slot length.
    assign sd_out  = live && (bitc < word_len) && shreg[SLOT_MAX-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask      <= '1;
            shreg     <= '0;
            hold      <= '0;
            live      <= 1'b0;
            empty     <= 1'b1;
            odd_empty <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            if (mask_wr)
                mask <= mask_in;
            if (slot_start) begin
                live <= load_go;
                if (load_go) begin
                    shreg     <= {hold, {PAD_W{1'b0}}};
                    empty     <= 1'b1;
                    odd_empty <= next_slot[0];
                    if (empty)
                        underrun <= 1'b1;
                end
            end else if (launch) begin
                shreg <= shreg << 1;
            end
            if (wr_en) begin
                hold      <= wr_data;
                empty     <= 1'b0;
                odd_empty <= 1'b0;
                underrun  <= 1'b0;
            end
        end
    end

    AST_MASKED_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        slot_start && !mask[next_slot] && !wr_en |=> !sd_oe && $stable(empty)) else $error("masked slot"); // R7

    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        load_go && !wr_en |=> empty) else $error("empty not set"); // R8

    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        load_go && empty && !wr_en |=> underrun) else $error("underrun missed"); // R9

endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx import tdm_tx_pkg::*; #(
    parameter int DIV_W   = 8,
    parameter int PRE_DIV = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_en,
    input  logic                net_mode,
    input  logic                bclk_pol,
    input  logic                fs_long,
    input  logic                fs_early,
    input  logic [4:0]          geom_code,
    input  logic [IDX_W-1:0]    last_slot,
    input  logic                pre8_en,
    input  logic [DIV_W-1:0]    div_m1,
    input  logic                mask_wr,
    input  logic [SLOT_MAX-1:0] mask_in,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                sd_out,
    output logic                sd_oe,
    output logic                bclk,
    output logic                fsync,
    output logic                fs_slot,
    output logic                empty,
    output logic                odd_empty,
    output logic                underrun
);
    geom_t            geom;
    fs_mode_e         fs_mode;
    logic [IDX_W-1:0] eff_last;
    logic             launch;
    logic [POS_W-1:0] bitc;
    logic             slot_start;
    logic [IDX_W-1:0] next_slot;
    logic             next_on;

    assign geom     = decode_geom(geom_code);
    assign eff_last = net_mode ? last_slot : '0;

    always_comb begin
        if (!fs_long)
            fs_mode = FS_BIT;
        else if (fs_early)
            fs_mode = FS_WORD_EARLY;
        else
            fs_mode = FS_WORD_ALIGNED;
    end

    tdm_bclk_gen #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_bclk (
        .clk     (clk),
        .rst     (rst),
        .pre_en  (pre8_en),
        .div_m1  (div_m1),
        .clk_pol (bclk_pol),
        .bclk    (bclk),
        .launch  (launch)
    );

    tdm_slot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .tx_en      (tx_en),
        .slot_len   (geom.slot_len),
        .word_len   (geom.word_len),
        .last_slot  (eff_last),
        .fs_mode    (fs_mode),
        .bitc       (bitc),
        .slot_start (slot_start),
        .next_slot  (next_slot),
        .next_on    (next_on),
        .fsync      (fsync),
        .fs_slot    (fs_slot)
    );

    tdm_tx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .slot_start (slot_start),
        .next_on    (next_on),
        .next_slot  (next_slot),
        .bitc       (bitc),
        .word_len   (geom.word_len),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .mask_wr    (mask_wr),
        .mask_in    (mask_in),
        .sd_out     (sd_out),
        .sd_oe      (sd_oe),
        .empty      (empty),
        .odd_empty  (odd_empty),
        .underrun   (underrun)
    );

endmodule

// File: tb/tdm_audio_tx_tb_top.sv
module tdm_audio_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0, net_mode = 1'b0, bclk_pol = 1'b0;
    logic        fs_long = 1'b0, fs_early = 1'b0, pre8_en = 1'b0;
    logic [4:0]  geom_code = 5'd14, last_slot = 5'd0;
    logic [7:0]  div_m1 = 8'd1;
    logic        mask_wr = 1'b0, wr_en = 1'b0;
    logic [31:0] mask_in = '1;
    logic [23:0] wr_data = '0;
    logic        sd_out, sd_oe, bclk, fsync, fs_slot, empty, odd_empty, underrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tdm_audio_tx dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .net_mode(net_mode), .bclk_pol(bclk_pol),
        .fs_long(fs_long), .fs_early(fs_early), .geom_code(geom_code), .last_slot(last_slot),
        .pre8_en(pre8_en), .div_m1(div_m1), .mask_wr(mask_wr), .mask_in(mask_in),
        .wr_en(wr_en), .wr_data(wr_data), .sd_out(sd_out), .sd_oe(sd_oe), .bclk(bclk),
        .fsync(fsync), .fs_slot(fs_slot), .empty(empty), .odd_empty(odd_empty),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Geometry from the counting rule: slot sizes ascending, fitting word sizes inside.
    function automatic void bench_geom(input int code, output int sl, output int wl);
        int k = 0;
        sl = 24;
        wl = 24;
        for (int s = 0; s < 6; s++) begin
            int ssz = (s < 5) ? 8 + 4 * s : 32;
            for (int w = 8; w <= 24 && w <= ssz; w += 4) begin
                if (k == code) begin
                    sl = ssz;
                    wl = w;
                end
                k++;
            end
        end
    endfunction

    function automatic logic [23:0] word_of(input int k);
        return 24'(k * 40503 + 1234567) ^ 24'h5A3C96;
    endfunction

    task automatic check_reset_state();
        check(bclk == 1'b0, "R12", "bclk", bclk, 0);
        check(sd_oe == 1'b0, "R12", "sd_oe", sd_oe, 0);
        check(fsync == 1'b0, "R12", "fsync", fsync, 0);
        check(fs_slot == 1'b0, "R12", "fs_slot", fs_slot, 0);
        check(empty == 1'b1, "R12", "empty", empty, 1);
        check(odd_empty == 1'b0, "R12", "odd_empty", odd_empty, 0);
        check(underrun == 1'b0, "R12", "underrun", underrun, 0);
    endtask

    // scen: 0 plain, 1 enable drop and restore, 2 skipped write
    task automatic run_case(input int code, input int nm1, input bit net, input bit fsl,
                            input bit fse, input bit pol, input logic [31:0] msk,
                            input int scen, input int frames, input string tag);
        int sl, wl, nsl, total, e, slot, bitn, frame, wcount;
        bit on, live, written, exp_empty, exp_sd, exp_fs, tail, prev_b, have_last;
        bit last_sd, last_oe, last_fs;
        logic [23:0] pending, cur;
        bench_geom(code, sl, wl);
        nsl   = net ? nm1 + 1 : 1;
        total = frames * nsl * sl;
        @(negedge clk);
        rst = 1'b1; tx_en = 1'b1; net_mode = net; fs_long = fsl; fs_early = fse;
        bclk_pol = pol; geom_code = 5'(code); last_slot = 5'(nm1);
        pre8_en = 1'b0; div_m1 = 8'd1; wr_en = 1'b0; mask_wr = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        wr_en = 1'b1; wr_data = word_of(0); pending = word_of(0); wcount = 1;
        written = 1; exp_empty = 0; cur = '0; on = 0; live = 0;
        mask_in = msk; mask_wr = (msk != '1);
        prev_b = 0; have_last = 0; e = 0;
        last_sd = 0; last_oe = 0; last_fs = 0;
        while (e < total) begin
            @(negedge clk);
            wr_en = 1'b0;
            mask_wr = 1'b0;
            if (bclk !== prev_b) begin
                if (bclk == !pol) begin
                    slot  = (e / sl) % nsl;
                    bitn  = e % sl;
                    frame = e / (sl * nsl);
                    if (bitn == 0) begin
                        on   = (slot == 0) ? bit'(tx_en) : (on && tx_en);
                        live = on && msk[slot];
                        if (live) begin
                            check(underrun == !written, "R9", "underrun at slot start", underrun, !written);
                            if (written) cur = pending;
                            check(empty == 1'b1, "R8", "empty after load", empty, 1);
                            check(odd_empty == slot[0], "R8", "odd_empty after load", odd_empty, slot[0]);
                            exp_empty = 1;
                            written = 0;
                        end else begin
                            check(empty == exp_empty, "R7", "empty in idle slot", empty, exp_empty);
                        end
                    end
                    check(sd_oe == live, msk[slot] ? ((scen == 1) ? "R10" : tag) : "R7",
                          "sd_oe", sd_oe, live);
                    if (live) begin
                        exp_sd = (bitn < wl) ? cur[23 - bitn] : 1'b0;
                        check(sd_out == exp_sd, (bitn >= wl) ? "R4" : tag, "sd_out", sd_out, exp_sd);
                    end
                    tail   = (slot == nsl - 1) && (bitn == sl - 1);
                    exp_fs = !fsl ? tail : (fse ? (tail || (slot == 0 && bitn < wl - 1))
                                                : (slot == 0 && bitn < wl));
                    check(fsync == exp_fs, "R5", "fsync", fsync, exp_fs);
                    check(fs_slot == (slot == 0), "R11", "fs_slot", fs_slot, slot == 0);
                    if (live && bitn == 1 && !(scen == 2 && frame == 1 && slot == 0)) begin
                        wr_en = 1'b1;
                        wr_data = word_of(wcount);
                        pending = word_of(wcount);
                        wcount++;
                        written = 1;
                        exp_empty = 0;
                    end
                    if (scen == 1 && frame == 1 && bitn == 2) begin
                        if (slot == 1) tx_en = 1'b0;
                        if (slot == 2) tx_en = 1'b1;
                    end
                    last_sd = sd_out; last_oe = sd_oe; last_fs = fsync;
                    have_last = 1;
                    e++;
                end else if (have_last) begin
                    check({sd_out, sd_oe, fsync} == {last_sd, last_oe, last_fs}, "R2",
                          "outputs moved on latch edge", {sd_out, sd_oe, fsync},
                          {last_sd, last_oe, last_fs});
                end
                prev_b = bclk;
            end
        end
    endtask

    task automatic clk_case(input bit pre, input int dv);
        int cnt, expv;
        bit pb;
        @(negedge clk);
        rst = 1'b1; pre8_en = pre; div_m1 = 8'(dv); bclk_pol = 1'b0; tx_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do begin pb = bclk; @(negedge clk); end while (!(bclk && !pb));
        cnt = 0;
        do begin pb = bclk; @(negedge clk); cnt++; end while (!(bclk && !pb));
        expv = (pre ? 8 : 1) * (dv + 1);
        if (expv < 2) expv = 2;
        expv = 2 * expv;
        check(cnt == expv, "R1", "bit clock period", cnt, expv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clk_case(1'b0, 0);
        clk_case(1'b0, 1);
        clk_case(1'b0, 4);
        clk_case(1'b1, 0);
        clk_case(1'b1, 3);
        clk_case(1'b1, 255);
        // every geometry code, rotating sync mode and polarity
        for (int c = 0; c < 32; c++) begin
            run_case(c, 1, 1'b1, (c % 3) != 0, (c % 3) == 2, c[0], '1, 0, 2, "R3");
        end
        // one-slot frames: last_slot ignored
        run_case(14, 5, 1'b0, 1'b0, 1'b0, 1'b0, '1, 0, 3, "R6");
        // masked slots 2, 5, 7 in an eight-slot frame
        run_case(0, 7, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FF5B, 0, 3, "R7");
        // enable dropped in slot 1 and restored in slot 2
        run_case(5, 3, 1'b1, 1'b1, 1'b1, 1'b1, '1, 1, 3, "R10");
        // write skipped for slot 0 of frame 1
        run_case(2, 2, 1'b1, 1'b1, 1'b0, 1'b0, '1, 2, 3, "R9");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule